// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a two-part logical address, a segment number and an offset inside that segment, into a physical address. It uses a small segment table held inside the unit. Each table slot stores a start address, a length, a valid flag and three access-permission flags: read, write and execute. A separate register holds how many segments are currently in use. A request must pass four tests. The segment number must be in range. The slot must be valid. The offset must lie inside the segment. The requested kind of access must be permitted. If all four pass, the unit returns the start address plus the offset one clock later. If any test fails, it returns a fault strobe with a two-bit cause code instead.

Supervisor software loads the table slots and the segment-count register through a configuration port. That port accepts writes only while the privilege input is high. The requester side uses a valid/ready handshake. The unit stops accepting requests during any cycle in which a privileged write is under way, so no translation ever uses a slot that is being changed.

Top module: `sat_unit`

## Requirements
- R1: After reset, `rsp_valid` and `fault` are low and `req_ready` is high. The segment count is 0 and every slot is invalid, so the first accepted request faults with cause 0.
- R2: A request is out of range when its segment number is greater than or equal to the segment count. It faults with cause code 0 even if the slot it names is valid.
- R3: A request to a slot whose valid flag is 0 faults with cause code 1.
- R4: A request whose offset is greater than or equal to the slot length faults with cause code 2. An offset of exactly length minus one is accepted.
- R5: The access kind `req_acc` is coded as follows: 0 is read and needs `perm[0]`, 1 is write and needs `perm[1]`, 2 is execute and needs `perm[2]`. Code 3 is never permitted. A missing permission faults with cause code 3.
- R6: When several tests fail, the cause reported is the first failing one in this order: range, valid, length, permission.
- R7: A request that passes every test raises `rsp_valid` for one cycle, one clock after the handshake. `rsp_addr` then equals the slot start plus the zero-extended offset, modulo 2^PA_W.
- R8: Configuration writes take effect only while `cfg_priv` and `cfg_we` are both high. `cfg_sel`=0 writes slot `cfg_idx` and `cfg_sel`=1 writes the segment count. A write with `cfg_priv` low changes nothing.
- R9: `req_ready` is low in any cycle with a privileged write. `rsp_valid` and `fault` are never high together. Both are low, and `rsp_addr` is 0, in the cycle after a clock edge with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_priv | input | 1 | Privileged (supervisor) mode indication |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: write a table slot, 1: write the segment count |
| cfg_idx | input | SEG_W | Slot index for a slot write |
| cfg_base | input | PA_W | Slot start physical address |
| cfg_limit | input | OFF_W+1 | Slot length |
| cfg_valid | input | 1 | Slot valid flag |
| cfg_perm | input | 3 | Slot permissions {exec, write, read} |
| cfg_count | input | SEG_W+1 | New segment count |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind |
| rsp_valid | output | 1 | Physical address valid |
| rsp_addr | output | PA_W | Translated physical address |
| fault | output | 1 | Translation fault strobe |
| fault_cause | output | 2 | Fault cause code |

## Verification
The hardest cases to reach are the ones where several tests fail in the same request. They show whether the cause priority is right. For example, a slot beyond the count may also be invalid, or an invalid slot may also be given an offset past its length. The bench loads slots so that a single request breaks two or three tests at once, and checks that only the highest-priority cause comes out. A request that collides with a privileged write is also forced. This shows that the stalled request gets no response. Unprivileged writes are then shown to leave both the count and a slot's start address unchanged.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_RANGE   = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_LIMIT   = 2'd2,
        CAUSE_PERM    = 2'd3
    } cause_e;

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    function automatic logic perm_grants(input logic [2:0] perm, input acc_e acc);
        logic g;
        case (acc)
            ACC_READ:  g = perm[PERM_RD];
            ACC_WRITE: g = perm[PERM_WR];
            ACC_EXEC:  g = perm[PERM_EX];
            default:   g = 1'b0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/sat_table.sv
module sat_table #(
    parameter int SEG_W = 3,
    parameter int PA_W  = 16,
    parameter int LIM_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LIM_W-1:0] wr_limit,
    input  logic             wr_valid,
    input  logic [2:0]       wr_perm,
    input  logic [SEG_W:0]   wr_count,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [LIM_W-1:0] rd_limit,
    output logic             rd_valid,
    output logic [2:0]       rd_perm,
    output logic [SEG_W:0]   count_q
);
    localparam int NSEG = 1 << SEG_W;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [LIM_W-1:0] limit;
        logic             valid;
        logic [2:0]       perm;
    } slot_t;

    slot_t slots [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && !wr_sel && (wr_idx == SEG_W'(g))) begin
                slot_d.base  = wr_base;
                slot_d.limit = wr_limit;
                slot_d.valid = wr_valid;
                slot_d.perm  = wr_perm;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign slots[g] = slot_q;
    end

    logic [SEG_W:0] count_d;

    always_comb begin
        count_d = count_q;
        if (wr_en && wr_sel) count_d = wr_count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    slot_t sel;
    assign sel      = slots[rd_idx];
    assign rd_base  = sel.base;
    assign rd_limit = sel.limit;
    assign rd_valid = sel.valid;
    assign rd_perm  = sel.perm;

endmodule

// File: rtl/sat_check.sv
module sat_check
    import sat_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic [SEG_W:0]   count,
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       acc,
    input  logic [PA_W-1:0]  e_base,
    input  logic [OFF_W:0]   e_limit,
    input  logic             e_valid,
    input  logic [2:0]       e_perm,
    output logic             pass,
    output cause_e           cause,
    output logic [PA_W-1:0]  phys
);
    logic in_range, in_limit, granted;

    always_comb begin
        in_range = ({1'b0, seg} < count);
        in_limit = ({1'b0, off} < e_limit);
        granted  = perm_grants(e_perm, acc_e'(acc));
        phys     = e_base + PA_W'(off);
        pass     = 1'b0;
        cause    = CAUSE_RANGE;
        if (!in_range)      cause = CAUSE_RANGE;
        else if (!e_valid)  cause = CAUSE_INVALID;
        else if (!in_limit) cause = CAUSE_LIMIT;
        else if (!granted)  cause = CAUSE_PERM;
        else                pass  = 1'b1;
    end

endmodule

// File: rtl/sat_unit.sv
module sat_unit
    import sat_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_priv,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [OFF_W:0]   cfg_limit,
    input  logic             cfg_valid,
    input  logic [2:0]       cfg_perm,
    input  logic [SEG_W:0]   cfg_count,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_addr,
    output logic             fault,
    output logic [1:0]       fault_cause
);
    localparam int LIM_W = OFF_W + 1;

    typedef struct packed {
        logic            ok;
        logic            flt;
        cause_e          cause;
        logic [PA_W-1:0] addr;
    } out_t;

    logic             cfg_wr;
    logic             fire;
    logic [SEG_W:0]   seg_count;
    logic [PA_W-1:0]  e_base;
    logic [LIM_W-1:0] e_limit;
    logic             e_valid;
    logic [2:0]       e_perm;
    logic             chk_pass;
    cause_e           chk_cause;
    logic [PA_W-1:0]  chk_phys;

    assign cfg_wr    = cfg_priv && cfg_we;
    assign req_ready = !cfg_wr;
    assign fire      = req_valid && req_ready;

    sat_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_sel   (cfg_sel),
        .wr_idx   (cfg_idx),
        .wr_base  (cfg_base),
        .wr_limit (cfg_limit),
        .wr_valid (cfg_valid),
        .wr_perm  (cfg_perm),
        .wr_count (cfg_count),
        .rd_idx   (req_seg),
        .rd_base  (e_base),
        .rd_limit (e_limit),
        .rd_valid (e_valid),
        .rd_perm  (e_perm),
        .count_q  (seg_count)
    );

    sat_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .count   (seg_count),
        .seg     (req_seg),
        .off     (req_off),
        .acc     (req_acc),
        .e_base  (e_base),
        .e_limit (e_limit),
        .e_valid (e_valid),
        .e_perm  (e_perm),
        .pass    (chk_pass),
        .cause   (chk_cause),
        .phys    (chk_phys)
    );

    out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (fire) begin
            if (chk_pass) begin
                out_d.ok   = 1'b1;
                out_d.addr = chk_phys;
            end else begin
                out_d.flt   = 1'b1;
                out_d.cause = chk_cause;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid   = out_q.ok;
    assign rsp_addr    = out_q.addr;
    assign fault       = out_q.flt;
    assign fault_cause = out_q.cause;

endmodule

// File: rtl/sat_unit_chk.sv
module sat_unit_chk #(
    parameter int SEG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_priv,
    input logic             cfg_we,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SEG_W-1:0] req_seg,
    input logic [SEG_W:0]   seg_count,
    input logic             rsp_valid,
    input logic             fault,
    input logic [1:0]       fault_cause
);
    AST_EXCLUSIVE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && fault)); // R9
    AST_STALL_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_priv && cfg_we) |-> !req_ready); // R9
    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || fault)); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> (!rsp_valid && !fault)); // R9
    AST_RANGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_seg} >= seg_count))
        |=> (fault && fault_cause == 2'd0)); // R2
    AST_COUNT_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_priv |=> $stable(seg_count)); // R8

endmodule

bind sat_unit sat_unit_chk #(.SEG_W(SEG_W)) u_sat_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_priv    (cfg_priv),
    .cfg_we      (cfg_we),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_seg     (req_seg),
    .seg_count   (seg_count),
    .rsp_valid   (rsp_valid),
    .fault       (fault),
    .fault_cause (fault_cause)
);

// File: tb/sat_unit_test.sv
module sat_unit_test;
    localparam int SEG_W = 3;
    localparam int OFF_W = 12;
    localparam int PA_W  = 16;
    localparam int NV    = 14;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_priv, cfg_we, cfg_sel, cfg_valid;
    logic [SEG_W-1:0] cfg_idx;
    logic [PA_W-1:0]  cfg_base;
    logic [OFF_W:0]   cfg_limit;
    logic [2:0]       cfg_perm;
    logic [SEG_W:0]   cfg_count;
    logic             req_valid, req_ready;
    logic [SEG_W-1:0] req_seg;
    logic [OFF_W-1:0] req_off;
    logic [1:0]       req_acc;
    logic             rsp_valid, fault;
    logic [PA_W-1:0]  rsp_addr;
    logic [1:0]       fault_cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sat_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) uut (.*);

    // {seg, off, acc, exp_ok, exp_fault, exp_cause, exp_addr}
    localparam logic [36:0] VEC [NV] = '{
        {3'd0, 12'h010, 2'd0, 1'b1, 1'b0, 2'd0, 16'h1010},  // R7 read
        {3'd0, 12'h0FF, 2'd1, 1'b1, 1'b0, 2'd0, 16'h10FF},  // R4 last legal offset
        {3'd0, 12'h100, 2'd0, 1'b0, 1'b1, 2'd2, 16'h0000},  // R4 offset == length
        {3'd1, 12'h0A0, 2'd0, 1'b1, 1'b0, 2'd0, 16'h0020},  // R7 wrap
        {3'd1, 12'h000, 2'd1, 1'b0, 1'b1, 2'd3, 16'h0000},  // R5 write on read-only
        {3'd2, 12'h000, 2'd0, 1'b0, 1'b1, 2'd1, 16'h0000},  // R3 invalid slot
        {3'd3, 12'h03F, 2'd2, 1'b1, 1'b0, 2'd0, 16'h203F},  // R5 execute granted
        {3'd3, 12'h010, 2'd0, 1'b0, 1'b1, 2'd3, 16'h0000},  // R5 read on exec-only
        {3'd5, 12'h000, 2'd0, 1'b0, 1'b1, 2'd0, 16'h0000},  // R2 valid slot beyond count
        {3'd4, 12'h000, 2'd0, 1'b0, 1'b1, 2'd0, 16'h0000},  // R2 seg == count
        {3'd3, 12'h040, 2'd0, 1'b0, 1'b1, 2'd2, 16'h0000},  // R6 length before permission
        {3'd2, 12'hFFF, 2'd1, 1'b0, 1'b1, 2'd1, 16'h0000},  // R6 valid before length
        {3'd0, 12'h000, 2'd3, 1'b0, 1'b1, 2'd3, 16'h0000},  // R5 reserved access
        {3'd7, 12'hFFF, 2'd3, 1'b0, 1'b1, 2'd0, 16'h0000}   // R6 range before all
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic priv, input logic sel, input logic [SEG_W-1:0] idx,
                             input logic [PA_W-1:0] base, input logic [OFF_W:0] lim,
                             input logic vld, input logic [2:0] perm, input logic [SEG_W:0] cnt);
        @(negedge clk);
        cfg_priv = priv; cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx;
        cfg_base = base; cfg_limit = lim; cfg_valid = vld; cfg_perm = perm; cfg_count = cnt;
        @(negedge clk);
        cfg_priv = 1'b0; cfg_we = 1'b0;
    endtask

    // drive one request; outputs are sampled 1 ns after the accepting edge
    task automatic request(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o, input logic [1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                $display("FAIL watchdog expired at cycle %0d", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_priv = 0; cfg_we = 0; cfg_sel = 0; cfg_idx = '0; cfg_base = '0;
        cfg_limit = '0; cfg_valid = 0; cfg_perm = '0; cfg_count = '0;
        req_valid = 0; req_seg = '0; req_off = '0; req_acc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R1 fault after reset", 32'(fault), 32'd0);
        check("R1 req_ready after reset", 32'(req_ready), 32'd1);
        request(3'd0, 12'h000, 2'd0);
        check("R1 empty table fault", 32'(fault), 32'd1);
        check("R1 empty table cause", 32'(fault_cause), 32'd0);

        // R8 unprivileged count write ignored
        cfg_write(1'b0, 1'b1, '0, '0, '0, 1'b0, 3'd0, 4'd8);
        cfg_write(1'b0, 1'b0, 3'd5, 16'h4000, 13'h100, 1'b1, 3'd7, '0);
        request(3'd5, 12'h000, 2'd0);
        check("R8 count unchanged without privilege", 32'(fault_cause), 32'd0);

        // table setup
        cfg_write(1'b1, 1'b1, '0, '0, '0, 1'b0, 3'd0, 4'd4);
        cfg_write(1'b1, 1'b0, 3'd0, 16'h1000, 13'h100, 1'b1, 3'b111, '0);
        cfg_write(1'b1, 1'b0, 3'd1, 16'hFF80, 13'h200, 1'b1, 3'b001, '0);
        cfg_write(1'b1, 1'b0, 3'd2, 16'h3000, 13'h080, 1'b0, 3'b111, '0);
        cfg_write(1'b1, 1'b0, 3'd3, 16'h2000, 13'h040, 1'b1, 3'b100, '0);
        cfg_write(1'b1, 1'b0, 3'd5, 16'h5000, 13'h100, 1'b1, 3'b111, '0);

        for (int i = 0; i < NV; i++) begin
            request(VEC[i][36:34], VEC[i][33:22], VEC[i][21:20]);
            check($sformatf("R2-R7 vector %0d rsp_valid (R7)", i), 32'(rsp_valid), 32'(VEC[i][19]));
            check($sformatf("vector %0d fault (R2 R3 R4 R5 R6)", i), 32'(fault), 32'(VEC[i][18]));
            if (VEC[i][18])
                check($sformatf("vector %0d cause (R6)", i), 32'(fault_cause), 32'(VEC[i][17:16]));
            check($sformatf("vector %0d rsp_addr (R7)", i), 32'(rsp_addr), 32'(VEC[i][15:0]));
        end

        // R8 unprivileged slot write ignored: slot 0 still maps to 0x1000
        cfg_write(1'b0, 1'b0, 3'd0, 16'h7000, 13'h100, 1'b1, 3'b111, '0);
        request(3'd0, 12'h004, 2'd0);
        check("R8 slot base unchanged", 32'(rsp_addr), 32'h1004);

        // R9 request collides with privileged write: stalled, no result
        @(negedge clk);
        cfg_priv = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b1; cfg_count = 4'd4;
        req_valid = 1'b1; req_seg = 3'd0; req_off = 12'h001; req_acc = 2'd0;
        #1;
        check("R9 ready low during privileged write", 32'(req_ready), 32'd0);
        @(posedge clk);
        #1;
        check("R9 no result for stalled request", 32'({rsp_valid, fault}), 32'd0);
        req_valid = 1'b0; cfg_priv = 1'b0; cfg_we = 1'b0;

        // R9 idle cycle clears outputs
        request(3'd0, 12'h020, 2'd2);
        check("R9 exec granted before idle", 32'(rsp_valid), 32'd1);
        @(posedge clk);
        #1;
        check("R9 idle outputs low", 32'({rsp_valid, fault}), 32'd0);
        check("R9 idle address zero", 32'(rsp_addr), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule